// File: doc/BRIEF.md
# External Interrupt Edge Aggregator

This block collects seven external interrupt lines (numbered 0 to 6) for an 8051-style microcontroller core. It synchronizes every asynchronous input and detects the edge that each line is defined to respond to. It then keeps one pending flag per line and raises a request toward the core for each line that is both pending and enabled. Lines 2, 4 and 6 are not wired to pins. Each one is fed by a small group of secondary event sources. Every secondary source has its own sticky flag and its own enable bit, and the enabled flags of a group are ORed into the line for that group.

Software reads and clears the pending flags of lines 2 to 6 through an 8-bit flag register, one bit per line. Bits may only be cleared, by writing zero under a bit mask. The core pulses a per-line acknowledge when it vectors to a handler, and this clears that line's primary flag. Secondary flags ignore the acknowledge and stay set until software clears them. Arbitration between lines, vector address generation and the core itself are outside this block.

Top module: `ext_irq_hub`

## Requirements
- R1: Lines 0 and 1 come from active-low pins (`dio_hi_n`, `dio_lo_n`). A falling edge sets the line's flag. A rising edge has no effect.
- R2: Line 3 comes from pin `busy3_pin`. `edge_sel[1]` = 0 selects a falling edge and 1 selects a rising edge, with falling as the intended setting. Line 2 is the active-low OR of its enabled secondary flags, so with `edge_sel[0]` = 0 it sets when that OR goes from 0 to 1. With `edge_sel[0]` = 1 it sets when the OR returns to 0.
- R3: Line 5 comes from pin `eebusy_pin`, which is inverted before a rising-edge detector. A falling pin edge sets the flag and a rising pin edge has no effect.
- R4: Line 6 sets when the OR of enabled secondary flags 4 (transfer done, rising edge of `xfer_evt`) and 5 (one-second tick, rising edge of `tick_evt`) goes from 0 to 1.
- R5: Line 4 sets when the OR of enabled secondary flags 2 and 3 goes from 0 to 1. Flag 2 is set by a rising edge of `lock_stat` and flag 3 by a falling edge.
- R6: Line 2's group consists of secondary flag 0 and secondary flag 1, set by rising edges of `col_evt[0]` and `col_evt[1]` respectively.
- R7: `flag_reg` bits 7, 6, 5, 4 and 3 hold the primary flags of lines 6, 5, 4, 3 and 2, and bits 2 to 0 read as zero. `sec_flag` bit j is secondary source j, numbered as in R4 to R6.
- R8: A pulse on `vec_ack[i]` clears primary flag i on the following clock edge and leaves every secondary flag unchanged.
- R9: A write with `reg_wr` or `sec_wr` high clears each flag whose mask bit is 1 and whose data bit is 0. Writing 1 changes nothing, and flags are set only by detected events.
- R10: `irq_req[i]` is primary flag i ANDed with `pri_en[i]`. A secondary flag whose `sec_en` bit is 0 cannot raise its group's primary flag, although the secondary flag itself still sets.
- R11: When a new event and a clear (acknowledge or software zero) hit the same flag on the same edge, the flag stays set.
- R12: A pin change shows in a flag on the third rising clock edge. A secondary event shows in its primary flag one edge later. Input levels present at reset never produce an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dio_hi_n | input | 1 | Line 0 pin, active low |
| dio_lo_n | input | 1 | Line 1 pin, active low |
| busy3_pin | input | 1 | Line 3 pin |
| eebusy_pin | input | 1 | Line 5 pin, active low |
| col_evt | input | 2 | Flash-write collision events, secondary sources 0 and 1 |
| lock_stat | input | 1 | Clock-lock status, secondary sources 2 (rise) and 3 (fall) |
| xfer_evt | input | 1 | Transfer-done event, secondary source 4 |
| tick_evt | input | 1 | One-second tick, secondary source 5 |
| edge_sel | input | 2 | Edge choice: bit 0 for line 2, bit 1 for line 3 (1 = rising) |
| pri_en | input | 7 | Request enable per line |
| sec_en | input | 6 | Enable per secondary source toward its line |
| vec_ack | input | 7 | Vector acknowledge strobe per line |
| reg_wr | input | 1 | Flag register write strobe |
| reg_wmask | input | 5 | Write mask for flag register bits 7 to 3 |
| reg_wdata | input | 5 | Write data for flag register bits 7 to 3 |
| sec_wr | input | 1 | Secondary flag write strobe |
| sec_wmask | input | 6 | Write mask for secondary flags |
| sec_wdata | input | 6 | Write data for secondary flags |
| flag_reg | output | 8 | Primary flag register |
| sec_flag | output | 6 | Secondary flags |
| irq_req | output | 7 | Request per line toward the core |

## Verification
The main sweep fires each of the six secondary sources under all 64 secondary-enable masks. This separates the per-source flag, which must always set, from the group's primary flag, which must follow that one enable bit only. Each pin is driven with both edge directions, and line 3 with both edge selections, to show that only the intended direction registers. A sweep over all 128 request-enable values with every line pending checks the request gating bit for bit. Acknowledges and clears are timed to land on the edge where a new event is set, so the set-wins rule is tested directly rather than inferred.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2
  } edge_kind_e;

  // index of each asynchronous input inside the synchronizer vector
  localparam int A_DIO0  = 0;
  localparam int A_DIO1  = 1;
  localparam int A_PIN3  = 2;
  localparam int A_PIN5  = 3;
  localparam int A_COL0  = 4;
  localparam int A_COL1  = 5;
  localparam int A_LOCK  = 6;
  localparam int A_XFER  = 7;
  localparam int A_TICK  = 8;
  localparam int N_ASYNC = 9;

  localparam int N_LINES = 7;
  localparam int N_SEC   = 6;

  function automatic logic edge_seen(input logic prev, input logic cur,
                                     input edge_kind_e kind);
    case (kind)
      EDGE_RISE: return ~prev & cur;
      EDGE_FALL: return prev & ~cur;
      default:   return prev ^ cur;
    endcase
  endfunction

  // set has priority over any clear
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

  // a clear happens only where mask = 1 and data = 0
  function automatic logic zero_write(input logic wr, input logic m,
                                      input logic d);
    return wr & m & ~d;
  endfunction

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev,
  output logic             armed
);
  localparam int CW    = $clog2(STAGES + 2);
  localparam int ARM_N = STAGES + 1;

  logic [WIDTH-1:0] chain [STAGES];
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      prev <= '0;
      cnt  <= '0;
    end else begin
      chain[0] <= async_in;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      prev <= chain[STAGES-1];
      if (cnt != CW'(ARM_N)) cnt <= cnt + 1'b1;
    end
  end

  assign cur   = chain[STAGES-1];
  assign armed = (cnt == CW'(ARM_N));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] q
);
  import irq_hub_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= flag_next(q[i], set[i], clr[i]);
    end
  end
endmodule

// File: rtl/ext_irq_hub.sv
module ext_irq_hub #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dio_hi_n,
  input  logic       dio_lo_n,
  input  logic       busy3_pin,
  input  logic       eebusy_pin,
  input  logic [1:0] col_evt,
  input  logic       lock_stat,
  input  logic       xfer_evt,
  input  logic       tick_evt,
  input  logic [1:0] edge_sel,
  input  logic [6:0] pri_en,
  input  logic [5:0] sec_en,
  input  logic [6:0] vec_ack,
  input  logic       reg_wr,
  input  logic [7:3] reg_wmask,
  input  logic [7:3] reg_wdata,
  input  logic       sec_wr,
  input  logic [5:0] sec_wmask,
  input  logic [5:0] sec_wdata,
  output logic [7:0] flag_reg,
  output logic [5:0] sec_flag,
  output logic [6:0] irq_req
);
  import irq_hub_pkg::*;

  logic [N_ASYNC-1:0] raw, s_cur, s_prev;
  logic               armed;

  // named internal events, also watched by the checker
  logic [N_LINES-1:0] pri_set, pri_clr, pend;
  logic [N_SEC-1:0]   sec_set, sec_clr;
  logic [2:0]         grp_line, grp_prev;
  edge_kind_e         kind2, kind3;

  assign raw = {tick_evt, xfer_evt, lock_stat, col_evt[1], col_evt[0],
                eebusy_pin, busy3_pin, dio_lo_n, dio_hi_n};

  irq_sync_edge #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw),
    .cur(s_cur), .prev(s_prev), .armed(armed)
  );

  // secondary sources
  assign sec_set[0] = armed & edge_seen(s_prev[A_COL0], s_cur[A_COL0], EDGE_RISE);
  assign sec_set[1] = armed & edge_seen(s_prev[A_COL1], s_cur[A_COL1], EDGE_RISE);
  assign sec_set[2] = armed & edge_seen(s_prev[A_LOCK], s_cur[A_LOCK], EDGE_RISE);
  assign sec_set[3] = armed & edge_seen(s_prev[A_LOCK], s_cur[A_LOCK], EDGE_FALL);
  assign sec_set[4] = armed & edge_seen(s_prev[A_XFER], s_cur[A_XFER], EDGE_RISE);
  assign sec_set[5] = armed & edge_seen(s_prev[A_TICK], s_cur[A_TICK], EDGE_RISE);

  for (genvar j = 0; j < N_SEC; j++) begin : g_sec_clr
    assign sec_clr[j] = zero_write(sec_wr, sec_wmask[j], sec_wdata[j]);
  end

  irq_flag_bank #(.WIDTH(N_SEC)) u_sec (
    .clk(clk), .rst_n(rst_n), .set(sec_set), .clr(sec_clr), .q(sec_flag)
  );

  // group lines: index 0 -> line 2, 1 -> line 4, 2 -> line 6
  for (genvar g = 0; g < 3; g++) begin : g_grp
    assign grp_line[g] = |(sec_flag[2*g +: 2] & sec_en[2*g +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_prev <= '0;
    else        grp_prev <= grp_line;
  end

  assign kind2 = edge_sel[0] ? EDGE_RISE : EDGE_FALL;
  assign kind3 = edge_sel[1] ? EDGE_RISE : EDGE_FALL;

  // primary lines; line 2 is active low, line 5 pin is inverted
  assign pri_set[0] = armed & edge_seen(s_prev[A_DIO0], s_cur[A_DIO0], EDGE_FALL);
  assign pri_set[1] = armed & edge_seen(s_prev[A_DIO1], s_cur[A_DIO1], EDGE_FALL);
  assign pri_set[2] = edge_seen(~grp_prev[0], ~grp_line[0], kind2);
  assign pri_set[3] = armed & edge_seen(s_prev[A_PIN3], s_cur[A_PIN3], kind3);
  assign pri_set[4] = edge_seen(grp_prev[1], grp_line[1], EDGE_RISE);
  assign pri_set[5] = armed & edge_seen(~s_prev[A_PIN5], ~s_cur[A_PIN5], EDGE_RISE);
  assign pri_set[6] = edge_seen(grp_prev[2], grp_line[2], EDGE_RISE);

  assign pri_clr[0] = vec_ack[0];
  assign pri_clr[1] = vec_ack[1];
  for (genvar i = 2; i < N_LINES; i++) begin : g_pri_clr
    assign pri_clr[i] = vec_ack[i] | zero_write(reg_wr, reg_wmask[i+1], reg_wdata[i+1]);
  end

  irq_flag_bank #(.WIDTH(N_LINES)) u_pri (
    .clk(clk), .rst_n(rst_n), .set(pri_set), .clr(pri_clr), .q(pend)
  );

  assign flag_reg = {pend[6:2], 3'b000};
  assign irq_req  = pend & pri_en;
endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] flag_reg,
  input logic [5:0] sec_flag,
  input logic [6:0] vec_ack,
  input logic       reg_wr,
  input logic [7:3] reg_wmask,
  input logic [7:3] reg_wdata,
  input logic       sec_wr,
  input logic [5:0] sec_wmask,
  input logic [5:0] sec_wdata,
  input logic [6:0] pend,
  input logic [6:0] pri_set,
  input logic [5:0] sec_set
);
  // R7: low bits of the flag register never read as one
  p_low_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_reg[2:0] == 3'b000);

  for (genvar i = 0; i < 7; i++) begin : g_pri
    logic sw_zero;
    if (i >= 2) begin : g_sw
      assign sw_zero = reg_wr & reg_wmask[i+1] & ~reg_wdata[i+1];
    end else begin : g_nosw
      assign sw_zero = 1'b0;
    end

    // R11: an event always leaves the flag pending
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pri_set[i] |=> pend[i]);

    // R8: a primary flag drops only after an acknowledge or zero write
    p_pend_drop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[i]) |-> $past(vec_ack[i] | sw_zero));
  end

  for (genvar j = 0; j < 6; j++) begin : g_sec
    // R9: secondary flags are set only by hardware events
    p_sec_rise_hw_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_flag[j]) |-> $past(sec_set[j]));

    // R9: a secondary flag holds until software writes zero to it
    p_sec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_flag[j] && !(sec_wr && sec_wmask[j] && !sec_wdata[j])) |=> sec_flag[j]);
  end
endmodule

bind ext_irq_hub irq_hub_checker i_chk (
  .clk(clk), .rst_n(rst_n), .flag_reg(flag_reg), .sec_flag(sec_flag),
  .vec_ack(vec_ack), .reg_wr(reg_wr), .reg_wmask(reg_wmask),
  .reg_wdata(reg_wdata), .sec_wr(sec_wr), .sec_wmask(sec_wmask),
  .sec_wdata(sec_wdata), .pend(pend), .pri_set(pri_set), .sec_set(sec_set)
);

// File: tb/test_ext_irq_hub.sv
module test_ext_irq_hub;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dio_hi_n, dio_lo_n, busy3_pin, eebusy_pin;
  logic [1:0] col_evt;
  logic       lock_stat, xfer_evt, tick_evt;
  logic [1:0] edge_sel;
  logic [6:0] pri_en;
  logic [5:0] sec_en;
  logic [6:0] vec_ack;
  logic       reg_wr;
  logic [7:3] reg_wmask, reg_wdata;
  logic       sec_wr;
  logic [5:0] sec_wmask, sec_wdata;
  logic [7:0] flag_reg;
  logic [5:0] sec_flag;
  logic [6:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_hub i_ext_irq_hub (
    .clk(clk), .rst_n(rst_n), .dio_hi_n(dio_hi_n), .dio_lo_n(dio_lo_n),
    .busy3_pin(busy3_pin), .eebusy_pin(eebusy_pin), .col_evt(col_evt),
    .lock_stat(lock_stat), .xfer_evt(xfer_evt), .tick_evt(tick_evt),
    .edge_sel(edge_sel), .pri_en(pri_en), .sec_en(sec_en), .vec_ack(vec_ack),
    .reg_wr(reg_wr), .reg_wmask(reg_wmask), .reg_wdata(reg_wdata),
    .sec_wr(sec_wr), .sec_wmask(sec_wmask), .sec_wdata(sec_wdata),
    .flag_reg(flag_reg), .sec_flag(sec_flag), .irq_req(irq_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    reg_wr = 1'b1; reg_wmask = '1; reg_wdata = '0;
    sec_wr = 1'b1; sec_wmask = '1; sec_wdata = '0;
    vec_ack = '1;
    step(1);
    reg_wr = 1'b0; sec_wr = 1'b0; vec_ack = '0;
    step(2);
  endtask

  // group bit in flag_reg for secondary source s: 0x08, 0x20, 0x80
  function automatic logic [7:0] grp_bit(input int s);
    return 8'h08 << (2 * (s / 2));
  endfunction

  initial begin
    dio_hi_n = 1; dio_lo_n = 1; busy3_pin = 1; eebusy_pin = 1;
    col_evt = 0; lock_stat = 1; xfer_evt = 0; tick_evt = 0;
    edge_sel = 0; pri_en = '1; sec_en = '1; vec_ack = 0;
    reg_wr = 0; reg_wmask = 0; reg_wdata = 0;
    sec_wr = 0; sec_wmask = 0; sec_wdata = 0;
    rst_n = 0;
    step(5);
    rst_n = 1;
    step(6);
    // R12: levels present at reset (lock high, pins high) make no event
    chk("R12 reset flag_reg", flag_reg, 0);
    chk("R12 reset sec_flag", sec_flag, 0);
    chk("R12 reset irq_req", irq_req, 0);

    // R5: lock falling sets secondary 3, then line 4 one edge later
    lock_stat = 0;
    step(3);
    chk("R5 lock fall sec", sec_flag, 6'h08);
    step(1);
    chk("R5 lock fall line4", flag_reg, 8'h20);
    clear_all();
    chk("R9 clear all", {flag_reg, 2'b00, sec_flag}, 0);

    // R1 and R12: pin lines 0 and 1, falling only, three-edge latency
    dio_hi_n = 0;
    step(2);
    chk("R12 latency line0", irq_req, 0);
    step(1);
    chk("R1 line0 fall", irq_req, 7'h01);
    dio_hi_n = 1;
    step(4);
    chk("R1 line0 rise ignored", irq_req, 7'h01);
    clear_all();
    dio_lo_n = 0;
    step(3);
    chk("R1 line1 fall", irq_req, 7'h02);
    clear_all();
    dio_lo_n = 1;
    step(4);
    chk("R1 line1 rise ignored", irq_req, 0);

    // R2: line 3 edge selection
    busy3_pin = 0;
    step(3);
    chk("R2 line3 fall default", flag_reg, 8'h10);
    clear_all();
    busy3_pin = 1;
    step(4);
    chk("R2 line3 rise ignored", flag_reg, 0);
    edge_sel[1] = 1;
    busy3_pin = 0;
    step(4);
    chk("R2 line3 fall ignored when rising", flag_reg, 0);
    busy3_pin = 1;
    step(3);
    chk("R2 line3 rise selected", flag_reg, 8'h10);
    edge_sel[1] = 0;
    clear_all();

    // R3: line 5 is falling-sensitive through the inversion
    eebusy_pin = 0;
    step(3);
    chk("R3 line5 fall", flag_reg, 8'h40);
    clear_all();
    eebusy_pin = 1;
    step(4);
    chk("R3 line5 rise ignored", flag_reg, 0);

    // R4 R5 R6 R10: every source under all 64 secondary-enable masks
    for (int m = 0; m < 64; m++) begin
      sec_en = 6'(m);
      for (int s = 0; s < 6; s++) begin
        case (s)
          0, 1: col_evt[s] = 1'b1;
          2: lock_stat = 1'b1;
          3: lock_stat = 1'b0;
          4: xfer_evt = 1'b1;
          default: tick_evt = 1'b1;
        endcase
        step(3);
        chk("R6 R5 R4 sweep sec flag", sec_flag, 32'(1) << s);
        step(1);
        chk("R10 sweep group line", flag_reg, m[s] ? grp_bit(s) : 8'h00);
        col_evt = 0; xfer_evt = 0; tick_evt = 0;
        step(3);
        clear_all();
      end
    end
    sec_en = '1;

    // R8 and R9: acknowledge clears primary only
    xfer_evt = 1;
    step(4);
    chk("R4 xfer pending", {flag_reg, 2'b00, sec_flag}, {8'h80, 8'h10});
    vec_ack[6] = 1;
    step(1);
    vec_ack[6] = 0;
    chk("R8 ack clears line6", flag_reg, 0);
    chk("R8 ack keeps secondary", sec_flag, 6'h10);
    eebusy_pin = 0;
    step(3);
    vec_ack[5] = 1;
    step(1);
    vec_ack[5] = 0;
    chk("R8 ack clears line5", flag_reg, 0);
    eebusy_pin = 1;
    xfer_evt = 0;
    tick_evt = 1;
    step(4);
    chk("R4 tick while xfer set keeps line6 low", flag_reg, 0);
    chk("R4 tick secondary", sec_flag, 6'h30);
    tick_evt = 0;

    // R9: writes of one do nothing, zero clears only the masked bit
    dio_hi_n = 0;
    step(3);
    reg_wr = 1; reg_wmask = '1; reg_wdata = '1;
    sec_wr = 1; sec_wmask = '1; sec_wdata = '1;
    step(1);
    reg_wr = 0; sec_wr = 0;
    chk("R9 write one ignored sec", sec_flag, 6'h30);
    chk("R9 write one ignored req", irq_req, 7'h01);
    sec_wr = 1; sec_wmask = 6'h10; sec_wdata = 6'h00;
    step(1);
    sec_wr = 0;
    chk("R9 zero write clears one sec bit", sec_flag, 6'h20);
    dio_hi_n = 1;
    clear_all();

    // R11: set wins over acknowledge and over software clear
    eebusy_pin = 0;
    step(3);
    eebusy_pin = 1;
    step(3);
    eebusy_pin = 0;
    step(2);
    vec_ack[5] = 1; reg_wr = 1; reg_wmask = 5'b01000; reg_wdata = 0;
    step(1);
    vec_ack[5] = 0; reg_wr = 0;
    chk("R11 line5 set beats clear", flag_reg, 8'h40);
    vec_ack[5] = 1;
    step(1);
    vec_ack[5] = 0;
    chk("R11 then ack clears", flag_reg, 0);
    eebusy_pin = 1;
    xfer_evt = 1;
    step(4);
    xfer_evt = 0;
    step(3);
    xfer_evt = 1;
    step(2);
    sec_wr = 1; sec_wmask = 6'h10; sec_wdata = 0;
    step(1);
    sec_wr = 0;
    chk("R11 secondary set beats clear", sec_flag, 6'h10);
    xfer_evt = 0;
    clear_all();

    // R2: line 2 with rising selection fires when its OR returns to 0
    edge_sel[0] = 1;
    col_evt[0] = 1;
    step(4);
    chk("R2 line2 rising no set on OR rise", flag_reg, 0);
    sec_wr = 1; sec_wmask = 6'h01; sec_wdata = 0;
    step(1);
    sec_wr = 0;
    step(1);
    chk("R2 line2 rising sets on OR fall", flag_reg, 8'h08);
    col_evt[0] = 0;
    edge_sel[0] = 0;
    step(3);
    clear_all();

    // R10 and R7: every line pending, sweep request enables
    dio_hi_n = 0; dio_lo_n = 0; busy3_pin = 0; eebusy_pin = 0;
    col_evt[1] = 1; lock_stat = 1; tick_evt = 1;
    step(5);
    chk("R7 all lines pending", flag_reg, 8'hF8);
    for (int e = 0; e < 128; e++) begin
      pri_en = 7'(e);
      step(1);
      chk("R10 request gating", irq_req, 32'(e));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule